// File: doc/BRIEF.md
# Write-only I2C configuration slave

This block is a Standard-mode I2C slave that accepts write transfers only. Its job is to load a small bank of control registers that configure a routing and drive stage elsewhere on the chip. It samples the serial clock and data lines with the system clock and detects START and STOP. A valid transfer has three bytes: the slave address with a write direction bit, a register pointer, and one data byte. The slave pulls the data line low to acknowledge each byte sent to its own address.

The registers appear as parallel outputs. One bank has one byte per output channel. The second bank holds one clamp/bias mode bit per input. Every committed write to a defined register raises a strobe for one system clock. A strap pin sets the top bit of the slave address, so two such blocks can share one bus. Pointers outside the register map are acknowledged, and the data is then dropped.

Top module: `i2c_cfg_slave`

## Requirements
- R1: After reset every register output is 0, `sda_oe_o` is 0 and `wr_stb_o` is 0.
- R2: The 8-bit address byte the slave answers (7-bit address plus R/W bit 0) is 0x06 when `addr_sel_i` is 0 and 0x86 when it is 1. The slave acknowledges that byte by asserting `sda_oe_o` during the ninth SCL pulse.
- R3: The slave does not acknowledge an address byte that differs from its own, or whose bit 0 (R/W) is 1. No register changes before the next START.
- R4: In a matching frame, the slave acknowledges the pointer byte and the data byte. The data is written to the register the pointer selects, and `wr_stb_o` is high for exactly one clock for that write.
- R5: Pointer p with 1 <= p <= 9 writes `out_ctrl_o[8*(p-1)+7 : 8*(p-1)]`.
- R6: Pointer 0x1D writes `clamp_mode_o[7:0]`, with input 1 at bit 0. Pointer 0x1E writes `clamp_mode_o[11:8]` from data bits 3:0, and data bits 7:4 are dropped.
- R7: A data byte sent to any other pointer is acknowledged but changes no register and raises no strobe.
- R8: A repeated START before the last data bit abandons the frame without a write, and the new frame is decoded from its address byte.
- R9: After the data byte, the slave acknowledges no further byte and makes no further write until the next START. After STOP the data line is released.
- R10: The slave releases the acknowledge drive while SCL is low, after the acknowledge pulse, and never changes it while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 20x the SCL rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| addr_sel_i | input | 1 | Address strap; 1 sets the top address bit |
| sda_oe_o | output | 1 | 1 pulls the data line low (acknowledge) |
| out_ctrl_o | output | 72 | Output-channel control bytes, channel 1 in the low byte |
| clamp_mode_o | output | 12 | Clamp/bias mode bit per input, input 1 at bit 0 |
| wr_stb_o | output | 1 | One-clock pulse for each committed register write |

## Verification
The bench uses the default build of 9 output registers, 12 input mode bits and a two-stage synchronizer. With these values the second clamp register is only half filled, so the bench can check that its upper data bits are dropped. It also exercises the unmapped pointers on both sides of each register range. SCL runs at 80 system clocks per bit. This leaves time for the synchronizer and the acknowledge timing, and it makes a mid-byte repeated START easy to place. The bench tests both strap settings against both address values, and sends a read-direction address to confirm it is ignored.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_ACK} rx_state_e;
  typedef enum logic [1:0] {BY_ADDR, BY_PTR, BY_DATA} byte_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] raw, cur, prv;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-1:0], raw[g]};
    end
    assign cur[g] = chain_q[STAGES-1];
    assign prv[g] = chain_q[STAGES];
  end

  assign scl_o      = cur[0];
  assign sda_o      = cur[1];
  assign scl_rise_o = cur[0] & ~prv[0];
  assign scl_fall_o = ~cur[0] & prv[0];
  // bus conditions need SCL high on both samples
  assign start_o    = cur[0] & prv[0] & prv[1] & ~cur[1];
  assign stop_o     = cur[0] & prv[0] & ~prv[1] & cur[1];
endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
  import i2c_cfg_pkg::*;
#(
  parameter logic [6:0] ADDR7_BASE = 7'h03
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       addr_sel_i,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  output logic       sda_oe_o,
  output logic       wr_en_o,
  output logic [7:0] wr_ptr_o,
  output logic [7:0] wr_data_o
);
  rx_state_e  state_q;
  byte_e      byte_q;
  logic [3:0] bit_cnt_q;
  logic [7:0] shreg_q, ptr_q, data_q;
  logic       oe_q, wr_en_q;
  logic [6:0] own_addr;
  logic       addr_hit;

  assign own_addr = {ADDR7_BASE[6] ^ addr_sel_i, ADDR7_BASE[5:0]};
  assign addr_hit = (shreg_q[7:1] == own_addr) && !shreg_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      byte_q    <= BY_ADDR;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      ptr_q     <= '0;
      data_q    <= '0;
      oe_q      <= 1'b0;
      wr_en_q   <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_i) begin
        state_q   <= ST_RX;
        byte_q    <= BY_ADDR;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        case (state_q)
          ST_RX: begin
            if (scl_rise_i && bit_cnt_q != 4'd8) begin
              shreg_q   <= {shreg_q[6:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
              case (byte_q)
                BY_ADDR: begin
                  if (addr_hit) begin
                    oe_q    <= 1'b1;
                    state_q <= ST_ACK;
                  end else begin
                    state_q <= ST_IDLE;
                  end
                end
                BY_PTR: begin
                  ptr_q   <= shreg_q;
                  oe_q    <= 1'b1;
                  state_q <= ST_ACK;
                end
                default: begin
                  data_q  <= shreg_q;
                  wr_en_q <= 1'b1;
                  oe_q    <= 1'b1;
                  state_q <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              oe_q      <= 1'b0;
              bit_cnt_q <= '0;
              case (byte_q)
                BY_ADDR: begin byte_q <= BY_PTR;  state_q <= ST_RX; end
                BY_PTR:  begin byte_q <= BY_DATA; state_q <= ST_RX; end
                default: state_q <= ST_IDLE;
              endcase
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_en_o   = wr_en_q;
  assign wr_ptr_o  = ptr_q;
  assign wr_data_o = data_q;

  p_ack_rise_scl_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> !scl_i);
  p_ack_fall_scl_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(oe_q) && !$past(start_i) && !$past(stop_i)) |-> !scl_i);
  p_idle_released_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !oe_q);
  p_start_restarts_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_RX && byte_q == BY_ADDR && bit_cnt_q == 4'd0));
  p_commit_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |=> !wr_en_q);
  p_commit_from_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_q |-> (byte_q == BY_DATA && state_q == ST_ACK));
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int         NUM_OUT    = 9,
  parameter int         OUT_BASE   = 1,
  parameter int         NUM_IN     = 12,
  parameter logic [7:0] CLAMP_BASE = 8'h1D
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [7:0]           wr_ptr_i,
  input  logic [7:0]           wr_data_i,
  output logic [NUM_OUT*8-1:0] out_ctrl_o,
  output logic [NUM_IN-1:0]    clamp_mode_o,
  output logic                 wr_stb_o
);
  localparam int NUM_CLAMP = (NUM_IN + 7) / 8;
  localparam int NUM_REGS  = NUM_OUT + NUM_CLAMP;

  logic [NUM_REGS-1:0] hit;
  logic                stb_q;

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    logic [7:0] val_q;
    assign hit[k] = wr_en_i && (wr_ptr_i == 8'(OUT_BASE + k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     val_q <= '0;
      else if (hit[k]) val_q <= wr_data_i;
    end
    assign out_ctrl_o[8*k +: 8] = val_q;
  end

  for (genvar j = 0; j < NUM_CLAMP; j++) begin : g_clamp
    localparam int W = ((NUM_IN - 8*j) > 8) ? 8 : (NUM_IN - 8*j);
    logic [W-1:0] bits_q;
    assign hit[NUM_OUT+j] = wr_en_i && (wr_ptr_i == 8'(CLAMP_BASE + 8'(j)));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               bits_q <= '0;
      else if (hit[NUM_OUT+j])   bits_q <= wr_data_i[W-1:0];
    end
    assign clamp_mode_o[8*j +: W] = bits_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_q <= 1'b0;
    else         stb_q <= |hit;
  end
  assign wr_stb_o = stb_q;

  p_unmapped_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !(|hit)) |=> ($stable(out_ctrl_o) && $stable(clamp_mode_o) && !wr_stb_o));
  p_no_write_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(out_ctrl_o) && $stable(clamp_mode_o)));
  p_stb_needs_commit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> $past(wr_en_i));
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave #(
  parameter int         NUM_OUT     = 9,
  parameter int         NUM_IN      = 12,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ADDR7_BASE  = 7'h03,
  parameter int         OUT_BASE    = 1,
  parameter logic [7:0] CLAMP_BASE  = 8'h1D
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic                 addr_sel_i,
  output logic                 sda_oe_o,
  output logic [NUM_OUT*8-1:0] out_ctrl_o,
  output logic [NUM_IN-1:0]    clamp_mode_o,
  output logic                 wr_stb_o
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       wr_en;
  logic [7:0] wr_ptr, wr_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_wr_fsm #(.ADDR7_BASE(ADDR7_BASE)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_sel_i (addr_sel_i),
    .scl_i      (scl_s),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (wr_en),
    .wr_ptr_o   (wr_ptr),
    .wr_data_o  (wr_data)
  );

  cfg_regfile #(
    .NUM_OUT    (NUM_OUT),
    .OUT_BASE   (OUT_BASE),
    .NUM_IN     (NUM_IN),
    .CLAMP_BASE (CLAMP_BASE)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en),
    .wr_ptr_i     (wr_ptr),
    .wr_data_i    (wr_data),
    .out_ctrl_o   (out_ctrl_o),
    .clamp_mode_o (clamp_mode_o),
    .wr_stb_o     (wr_stb_o)
  );
endmodule

// File: tb/sim_i2c_cfg_slave.sv
`timescale 1ns/1ps
module sim_i2c_cfg_slave;
  localparam int Q = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic        addr_sel = 1'b0;
  logic        sda_bus;
  logic        sda_oe;
  logic [71:0] out_ctrl;
  logic [11:0] clamp_mode;
  logic        wr_stb;

  int n_chk = 0;
  int n_fail = 0;
  int stb_cnt = 0;
  int exp_stb = 0;
  logic [71:0] m_ctrl = '0;
  logic [11:0] m_clamp = '0;

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_cfg_slave u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .scl_i        (scl),
    .sda_i        (sda_bus),
    .addr_sel_i   (addr_sel),
    .sda_oe_o     (sda_oe),
    .out_ctrl_o   (out_ctrl),
    .clamp_mode_o (clamp_mode),
    .wr_stb_o     (wr_stb)
  );

  always @(posedge clk) if (rst_n && wr_stb) stb_cnt <= stb_cnt + 1;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q);
    ack = !sda_bus;
    wq(Q); scl = 1'b0; wq(Q);
    chk("R10 ack released after slot", sda_oe, 1'b0);
  endtask

  function automatic bit mapped(input logic [7:0] p);
    return (p >= 8'h01 && p <= 8'h09) || p == 8'h1D || p == 8'h1E;
  endfunction

  function automatic void apply(input logic [7:0] p, input logic [7:0] d);
    if (p >= 8'h01 && p <= 8'h09) m_ctrl[8*(p-1) +: 8] = d;
    else if (p == 8'h1D) m_clamp[7:0] = d;
    else if (p == 8'h1E) m_clamp[11:8] = d[3:0];
  endfunction

  task automatic check_regs(input string req);
    chk(req, out_ctrl, m_ctrl);
    chk(req, clamp_mode, m_clamp);
    chk(req, stb_cnt, exp_stb);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] p, input logic [7:0] d,
                          input bit exp_ack, input string req);
    logic a0, a1, a2;
    bus_start;
    send_byte(a, a0);
    send_byte(p, a1);
    send_byte(d, a2);
    bus_stop;
    chk(req, {a0, a1, a2}, exp_ack ? 3'b111 : 3'b000);
    if (exp_ack && mapped(p)) begin
      apply(p, d);
      exp_stb++;
    end
    check_regs(req);
  endtask

  task automatic t_reset;
    chk("R1 sda_oe", sda_oe, 1'b0);
    chk("R1 strobe", wr_stb, 1'b0);
    check_regs("R1 reset state");
  endtask

  task automatic t_out_regs;
    addr_sel = 1'b0;
    for (int p = 1; p <= 9; p++)
      do_write(8'h06, 8'(p), 8'(8'h11 * p + 8'h30), 1'b1, "R5 out ctrl write");
    do_write(8'h06, 8'h05, 8'hC3, 1'b1, "R4 rewrite");
  endtask

  task automatic t_addr_strap;
    addr_sel = 1'b1;
    do_write(8'h06, 8'h02, 8'hEE, 1'b0, "R3 low address with strap high");
    do_write(8'h86, 8'h02, 8'h7E, 1'b1, "R2 address 0x86");
    addr_sel = 1'b0;
    do_write(8'h86, 8'h03, 8'h99, 1'b0, "R3 high address with strap low");
    do_write(8'h06, 8'h03, 8'h42, 1'b1, "R2 address 0x06");
  endtask

  task automatic t_rw_bit;
    addr_sel = 1'b0;
    do_write(8'h07, 8'h01, 8'h5A, 1'b0, "R3 read bit set");
    addr_sel = 1'b1;
    do_write(8'h87, 8'h1D, 8'hFF, 1'b0, "R3 read bit set strap high");
    addr_sel = 1'b0;
  endtask

  task automatic t_clamp;
    do_write(8'h06, 8'h1D, 8'hA5, 1'b1, "R6 clamp low byte");
    do_write(8'h06, 8'h1E, 8'hF6, 1'b1, "R6 clamp upper nibble");
    do_write(8'h06, 8'h1E, 8'h09, 1'b1, "R6 clamp upper rewrite");
  endtask

  task automatic t_unmapped;
    do_write(8'h06, 8'h00, 8'hFF, 1'b1, "R7 pointer 0x00");
    do_write(8'h06, 8'h0A, 8'hFF, 1'b1, "R7 pointer 0x0A");
    do_write(8'h06, 8'h1C, 8'hFF, 1'b1, "R7 pointer 0x1C");
    do_write(8'h06, 8'h1F, 8'hFF, 1'b1, "R7 pointer 0x1F");
  endtask

  task automatic t_restart;
    logic a0, a1;
    bus_start;
    send_byte(8'h06, a0);
    send_byte(8'h03, a1);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    chk("R8 first frame acks", {a0, a1}, 2'b11);
    do_write(8'h06, 8'h04, 8'h5A, 1'b1, "R8 frame after repeated start");
  endtask

  task automatic t_extra;
    logic a0, a1, a2, a3;
    bus_start;
    send_byte(8'h06, a0);
    send_byte(8'h08, a1);
    send_byte(8'h3C, a2);
    send_byte(8'hFF, a3);
    bus_stop;
    apply(8'h08, 8'h3C);
    exp_stb++;
    chk("R9 acks then no ack", {a0, a1, a2, a3}, 4'b1110);
    check_regs("R9 single write");
    chk("R9 released after stop", sda_oe, 1'b0);
  endtask

  initial begin
    wq(5);
    rst_n = 1'b1;
    wq(5);
    t_reset;
    t_out_regs;
    t_addr_strap;
    t_rw_bit;
    t_clamp;
    t_unmapped;
    t_restart;
    t_extra;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule